// File: doc/BRIEF.md
# Sector Error Statistics Aggregator

This block reduces the per-sector corrected-bit counts that a page decoder leaves in its count registers to three page-level figures. Each figure is the result of one run: the sum of corrected bits, the number of sectors beyond repair, and the worst single-sector bitflip count. A run begins with a one-cycle `start` that carries the number of sectors. The block then reads the packed count words through a simple word-read port and takes one sector per clock. It ends with a one-cycle `done`.

The count words are 32 bits wide and hold four one-byte sector fields. Only the low six or seven bits of each field are meaningful. The `mask7` input picks the width. A field whose masked value is all ones marks a sector that the decoder could not correct. Such a sector is counted on its own and takes no part in the sum or the maximum.

Top module: `sector_err_stats`

## Requirements
- R1: After reset, `total`, `failed`, `max_flip`, `done`, `busy` and `rd_en` are all zero.
- R2: Sector i is read from word i/4, bits [8*(i%4)+7 : 8*(i%4)]. The block asserts `rd_en` with `rd_addr` = word index and takes `rd_data` on the following cycle. Each word is fetched exactly once per run, so a run of K sectors makes ceil(K/4) reads, and `rd_en` is never high two cycles in a row.
- R3: The field value is the byte ANDed with 0x7F when `mask7`=1 and with 0x3F when `mask7`=0, with `mask7` sampled at start. Bits above the mask have no effect.
- R4: A field value equal to the mask raises `failed` by one and leaves `total` and `max_flip` unchanged.
- R5: `total` is the sum of the field values of all correctable sectors.
- R6: `max_flip` is the largest field value among correctable sectors, or 0 if there are none.
- R7: An accepted start clears `total`, `failed` and `max_flip` on the next clock edge.
- R8: A start with `num_sec`=0 asserts `done` on the next edge with all outputs zero, and no read is issued.
- R9: `done` is high for exactly one cycle. The outputs then hold their values until the next accepted start.
- R10: A start that arrives while `busy` is high is ignored, and the running result is unchanged.
- R11: A `num_sec` above NSEC_MAX (16) is treated as NSEC_MAX.
- R12: For K sectors (after clamping), `done` rises K + ceil(K/4) clock edges after the edge that accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (accepted when idle) |
| num_sec | input | 5 | Number of sectors in the page |
| mask7 | input | 1 | 1: 7-bit count fields, 0: 6-bit fields |
| rd_en | output | 1 | Word read request |
| rd_addr | output | 2 | Word index being read |
| rd_data | input | 32 | Word returned one cycle after rd_en |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| total | output | 11 | Sum of corrected bits |
| failed | output | 5 | Count of uncorrectable sectors |
| max_flip | output | 7 | Largest correctable per-sector count |

## Verification
Every sector count from 0 to 17 is run, plus 31, in both field widths and against five data patterns:
- All-zero fields separate a clean page from an empty run.
- Fields with junk in the upper bits show that masking is applied.
- All-ones bytes make every sector uncorrectable.
- 0x3F bytes are correctable at seven bits but failed at six, so they tell the two widths apart.
- A mix of all-ones fields and small values exercises the sum and the maximum together.

Each run also checks the read count, the completion latency, and that outputs hold after done. On some runs a second start is injected mid-run to show that it is ignored.

// File: rtl/sector_err_stats.sv
`timescale 1ns/1ps
module sector_err_stats #(
  parameter int NSEC_MAX = 16,
  localparam int CNT_W  = $clog2(NSEC_MAX + 1),
  localparam int ADDR_W = (NSEC_MAX > 4) ? $clog2((NSEC_MAX + 3) / 4) : 1,
  localparam int SUM_W  = $clog2(NSEC_MAX * 127 + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  num_sec,
  input  logic              mask7,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [31:0]       rd_data,
  output logic              busy,
  output logic              done,
  output logic [SUM_W-1:0]  total,
  output logic [CNT_W-1:0]  failed,
  output logic [6:0]        max_flip
);
  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_PROC} st_t;
  st_t st;

  logic [CNT_W-1:0] idx, cnt;
  logic             fresh, m7;
  logic [31:0]      wreg;

  wire [CNT_W-1:0] req   = (num_sec > CNT_W'(NSEC_MAX)) ? CNT_W'(NSEC_MAX) : num_sec;
  wire [31:0]      word  = fresh ? rd_data : wreg;
  wire [7:0]       sbyte = word[{idx[1:0], 3'b000} +: 8];
  wire [6:0]       mask  = m7 ? 7'h7f : 7'h3f;
  wire [6:0]       fld   = sbyte[6:0] & mask;
  wire             bad   = (fld == mask);
  wire [CNT_W-1:0] nxt   = idx + 1'b1;

  assign busy    = (st != S_IDLE);
  assign rd_en   = (st == S_FETCH);
  assign rd_addr = ADDR_W'(idx >> 2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      idx      <= '0;
      cnt      <= '0;
      fresh    <= 1'b0;
      m7       <= 1'b0;
      wreg     <= '0;
      done     <= 1'b0;
      total    <= '0;
      failed   <= '0;
      max_flip <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          total    <= '0;
          failed   <= '0;
          max_flip <= '0;
          idx      <= '0;
          cnt      <= req;
          m7       <= mask7;
          if (req == '0) done <= 1'b1;
          else           st   <= S_FETCH;
        end
        S_FETCH: begin
          fresh <= 1'b1;
          st    <= S_PROC;
        end
        S_PROC: begin
          fresh <= 1'b0;
          if (fresh) wreg <= rd_data;
          if (bad) failed <= failed + 1'b1;
          else begin
            total <= total + SUM_W'(fld);
            if (fld > max_flip) max_flip <= fld;
          end
          idx <= nxt;
          if (nxt == cnt) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else if (nxt[1:0] == 2'b00) begin
            st <= S_FETCH;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sector_err_stats_chk.sv
`timescale 1ns/1ps
module sector_err_stats_chk #(
  parameter int NSEC_MAX = 16,
  localparam int CNT_W  = $clog2(NSEC_MAX + 1),
  localparam int SUM_W  = $clog2(NSEC_MAX * 127 + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [CNT_W-1:0] num_sec,
  input logic             rd_en,
  input logic             busy,
  input logic             done,
  input logic [SUM_W-1:0] total,
  input logic [CNT_W-1:0] failed,
  input logic [6:0]       max_flip
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
  AST_NO_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !done); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(total) && $stable(failed) && $stable(max_flip))); // R9
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (total == '0 && failed == '0 && max_flip == '0)); // R7
  AST_EMPTY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && num_sec == '0) |=> (done && !busy && !rd_en)); // R8
  AST_FETCH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) rd_en |=> !rd_en); // R2
  AST_FAIL_BOUND: assert property (@(posedge clk) disable iff (!rst_n) failed <= CNT_W'(NSEC_MAX)); // R11
  AST_SUM_COVERS_MAX: assert property (@(posedge clk) disable iff (!rst_n) total >= SUM_W'(max_flip)); // R6
endmodule

bind sector_err_stats sector_err_stats_chk #(.NSEC_MAX(NSEC_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .num_sec(num_sec), .rd_en(rd_en),
  .busy(busy), .done(done), .total(total), .failed(failed), .max_flip(max_flip)
);

// File: tb/sim_sector_err_stats.sv
`timescale 1ns/1ps
module sim_sector_err_stats;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 16;

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, mask7 = 1'b0;
  logic [4:0]  num_sec = '0;
  logic        rd_en;
  logic [1:0]  rd_addr;
  logic [31:0] rd_data = '0;
  logic        busy, done;
  logic [10:0] total;
  logic [4:0]  failed;
  logic [6:0]  max_flip;
  logic [31:0] mem [4];
  int checks = 0, fails = 0, reads = 0, cyc = 0;

  sector_err_stats #(.NSEC_MAX(NS)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .num_sec(num_sec), .mask7(mask7),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .done(done),
    .total(total), .failed(failed), .max_flip(max_flip));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rd_en) begin
      rd_data <= mem[rd_addr];
      reads   <= reads + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int pb(input int pat, input int i);
    case (pat)
      0: return 0;
      1: return (i * 37 + 11) & 255;
      2: return 255;
      3: return (i % 2 != 0) ? 8'hbf : 8'h3f;
      default: return (i % 3 == 0) ? 8'h7f : i * 4;
    endcase
  endfunction

  task automatic run(input int k, input bit m7, input int pat, input bit poke);
    int ke, mk, et, ef, em, lat, r0, f;
    logic [10:0] ht; logic [4:0] hf; logic [6:0] hm;
    ke = (k > NS) ? NS : k;
    mk = m7 ? 127 : 63;
    et = 0; ef = 0; em = 0; lat = 0;
    for (int i = 0; i < ke; i++) begin
      f = pb(pat, i) & mk;
      if (f == mk) ef++;
      else begin et += f; if (f > em) em = f; end
    end
    for (int w = 0; w < 4; w++)
      for (int j = 0; j < 4; j++) mem[w][8*j +: 8] = 8'(pb(pat, 4*w + j));
    @(negedge clk);
    num_sec = 5'(k); mask7 = m7; start = 1'b1; r0 = reads;
    @(posedge clk); #1;
    start = 1'b0;
    if (ke > 0)
      chk(total == 0 && failed == 0 && max_flip == 0, "R7 clear", int'(total) + int'(failed) + int'(max_flip), 0);
    while (!done && lat < 300) begin
      if (poke && lat == 3) begin start = 1'b1; num_sec = 5'd1; end
      else start = 1'b0;
      @(posedge clk); #1;
      lat++;
    end
    start = 1'b0;
    chk(lat == ke + (ke + 3) / 4, k > NS ? "R11 latency" : "R12 latency", lat, ke + (ke + 3) / 4);
    chk(int'(total) == et, poke ? "R10 total" : "R5 total", int'(total), et);
    chk(int'(failed) == ef, "R4 failed", int'(failed), ef);
    chk(int'(max_flip) == em, pat == 3 ? "R3 max" : "R6 max", int'(max_flip), em);
    chk(reads - r0 == (ke + 3) / 4, ke == 0 ? "R8 reads" : "R2 reads", reads - r0, (ke + 3) / 4);
    ht = total; hf = failed; hm = max_flip;
    @(posedge clk); #1;
    chk(!done, "R9 pulse", int'(done), 0);
    repeat (2) @(posedge clk);
    #1;
    chk(total == ht && failed == hf && max_flip == hm, "R9 hold", int'(total), int'(ht));
  endtask

  initial begin
    wait (cyc >= 150000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int w = 0; w < 4; w++) mem[w] = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(total == 0 && failed == 0 && max_flip == 0, "R1 outputs", int'(total) + int'(failed), 0);
    chk(!done && !busy && !rd_en, "R1 control", int'(done) + int'(busy) + int'(rd_en), 0);
    @(negedge clk); rst_n = 1'b1;
    for (int m = 0; m < 2; m++)
      for (int p = 0; p < 5; p++) begin
        for (int k = 0; k <= 17; k++) run(k, m[0], p, (p == 1) && (k >= 4));
        run(31, m[0], p, 1'b0);
      end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule